// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects five interrupt sources into a 16-bit status word, filters them through a 16-bit mask register with the same layout, and drives one combined interrupt request. Four of the sources are level signals from the synchronous serial and UART blocks, and the status word shows them as they are. The fifth source is a keyboard interrupt that the block generates. It ORs either the lower six or all eight keyboard lines, selected by a mode input, and holds the result in a latch. The latch clears only when software writes to a dedicated end-of-interrupt address.

Software reaches the block through a small register port. Offset 0 returns the status word. Offset 1 is the read/write mask. A write of any data to offset 2 acknowledges the keyboard interrupt. Reads return data combinationally from the current address. Writes take effect on the rising clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: A read at offset 0 returns the status word with the keyboard latch at bit 0, serial receive at bit 1, serial transmit at bit 2, UART transmit at bit 12 and UART receive at bit 13; each of these bits is 1 while its source is active.
- R2: Bits 15:14 and 11:3 read as 0 in both the status word and the mask, and writes to those mask bits have no effect.
- R3: Offset 1 is the mask register with the same bit layout as the status word; it resets to 0, and a write with bus_we_i high updates it on that clock edge.
- R4: With kbd_narrow_i high, only keyboard lines 5:0 can set the keyboard latch and lines 7:6 are ignored; with kbd_narrow_i low, any of lines 7:0 can set it. The latch reads 1 in the cycle after the rising edge at which a selected line was high.
- R5: Once set, the keyboard latch stays set until a write to offset 2 (data ignored), and it reads 0 after that edge.
- R6: If a selected keyboard line is high at the same edge as an end-of-interrupt write, the latch stays set.
- R7: A keyboard line pulse lasting one clock cycle sets the latch, because the inputs are not filtered.
- R8: irq_o is the OR of status AND mask over all bits, and it follows the status and the mask in the same cycle.
- R9: The status word shows raw source state whatever the mask holds.
- R10: A write to offset 0 or offset 3 changes neither the mask nor the keyboard latch, and a read at offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| kbd_lines_i | input | 8 | Raw keyboard lines |
| kbd_narrow_i | input | 1 | 1: only lines 5:0 raise the keyboard interrupt |
| ssi_rx_irq_i | input | 1 | Serial receive interrupt level |
| ssi_tx_irq_i | input | 1 | Serial transmit interrupt level |
| uart_tx_irq_i | input | 1 | UART transmit interrupt level |
| uart_rx_irq_i | input | 1 | UART receive interrupt level |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
Peripheral levels appear in the status word and on irq_o in the same cycle they are driven. The keyboard latch, mask writes and end-of-interrupt writes take effect one rising edge later. The bench drives inputs just after the falling edge and compares bus_rdata_o and irq_o against its model shortly afterwards. It then advances the model at the rising edge. As a result, every registered result is checked in the first cycle it is due, and combinational results are checked in the cycle of their stimulus. Single-cycle keyboard pulses and simultaneous set and acknowledge are placed on chosen edges so that the latch priority can be seen.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned POS_KBD  = 0;
  localparam int unsigned POS_SRX  = 1;
  localparam int unsigned POS_STX  = 2;
  localparam int unsigned POS_UTX  = 12;
  localparam int unsigned POS_URX  = 13;

  localparam logic [STAT_W-1:0] IMPL_MASK =
      (STAT_W'(1) << POS_KBD) | (STAT_W'(1) << POS_SRX) | (STAT_W'(1) << POS_STX) |
      (STAT_W'(1) << POS_UTX) | (STAT_W'(1) << POS_URX);

  typedef struct packed {
    logic kbd;
    logic ssi_rx;
    logic ssi_tx;
    logic uart_tx;
    logic uart_rx;
  } irq_src_t;
endpackage

// File: rtl/irq_kbd_latch.sv
module irq_kbd_latch #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned NARROW = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lines_i,
  input  logic             narrow_i,
  input  logic             eoi_i,
  output logic             pend_o
);
  logic [LINES-1:0] lane_en;
  logic             hit;

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    if (g < NARROW) begin : g_always
      assign lane_en[g] = 1'b1;
    end else begin : g_wide
      assign lane_en[g] = ~narrow_i;
    end
  end

  assign hit = |(lines_i & lane_en);

  // set wins over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_o <= 1'b0;
    else if (hit)     pend_o <= 1'b1;
    else if (eoi_i)   pend_o <= 1'b0;
  end

  AST_KBD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lines_i[0]) |=> pend_o);  // R4
  AST_KBD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !eoi_i) |=> pend_o);  // R5
  AST_KBD_SET_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && lines_i[1]) |=> pend_o);  // R6
  AST_KBD_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && narrow_i && lines_i[NARROW-1:0] == '0) |=> !pend_o);  // R4
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i & IMPL;
  end

  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));  // R3
endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack
  import irq_ctrl_pkg::*;
(
  input  irq_src_t          src_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o          = '0;
    status_o[POS_KBD] = src_i.kbd;
    status_o[POS_SRX] = src_i.ssi_rx;
    status_o[POS_STX] = src_i.ssi_tx;
    status_o[POS_UTX] = src_i.uart_tx;
    status_o[POS_URX] = src_i.uart_rx;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned KBD_W    = 8,
  parameter int unsigned KBD_NAR  = 6,
  parameter int unsigned OFS_STAT = 0,
  parameter int unsigned OFS_MASK = 1,
  parameter int unsigned OFS_EOI  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [STAT_W-1:0] bus_wdata_i,
  output logic [STAT_W-1:0] bus_rdata_o,
  input  logic [KBD_W-1:0]  kbd_lines_i,
  input  logic              kbd_narrow_i,
  input  logic              ssi_rx_irq_i,
  input  logic              ssi_tx_irq_i,
  input  logic              uart_tx_irq_i,
  input  logic              uart_rx_irq_i,
  output logic              irq_o
);
  logic              sel_stat, sel_mask, sel_eoi;
  logic              kbd_pend;
  logic [STAT_W-1:0] status, mask;
  irq_src_t          src;

  assign sel_stat = (bus_addr_i == ADDR_W'(OFS_STAT));
  assign sel_mask = (bus_addr_i == ADDR_W'(OFS_MASK));
  assign sel_eoi  = (bus_addr_i == ADDR_W'(OFS_EOI));

  irq_kbd_latch #(.LINES(KBD_W), .NARROW(KBD_NAR)) u_kbd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (kbd_lines_i),
    .narrow_i (kbd_narrow_i),
    .eoi_i    (bus_we_i & sel_eoi),
    .pend_o   (kbd_pend)
  );

  irq_mask_reg #(.W(STAT_W), .IMPL(IMPL_MASK)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i & sel_mask),
    .wdata_i (bus_wdata_i),
    .mask_o  (mask)
  );

  assign src = '{kbd: kbd_pend, ssi_rx: ssi_rx_irq_i, ssi_tx: ssi_tx_irq_i,
                 uart_tx: uart_tx_irq_i, uart_rx: uart_rx_irq_i};

  irq_status_pack u_pack (
    .src_i    (src),
    .status_o (status)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (sel_stat)      bus_rdata_o = status;
    else if (sel_mask) bus_rdata_o = mask;
  end

  assign irq_o = |(status & mask);

  AST_RSVD_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status & ~IMPL_MASK) == '0);  // R2
  AST_RSVD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask & ~IMPL_MASK) == '0);  // R2
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);  // R8
  AST_RAW_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_stat |-> (bus_rdata_o[POS_SRX] == ssi_rx_irq_i && bus_rdata_o[POS_URX] == uart_rx_irq_i));  // R9
  AST_STAT_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && sel_stat) |=> $stable(mask));  // R10
endmodule

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  kbd = '0;
  logic        narrow = 1'b0;
  logic        srx = 0, stx = 0, utx = 0, urx = 0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_latch = 0;
  logic [15:0] m_mask = '0;

  always #10 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .kbd_lines_i(kbd),
    .kbd_narrow_i(narrow), .ssi_rx_irq_i(srx), .ssi_tx_irq_i(stx),
    .uart_tx_irq_i(utx), .uart_rx_irq_i(urx), .irq_o(irq)
  );

  function automatic logic [15:0] exp_status();
    logic [15:0] s = '0;
    s[0] = m_latch; s[1] = srx; s[2] = stx; s[12] = utx; s[13] = urx;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // inputs are set just after a falling edge; compare, then clock the model
  task automatic cyc(input string tag);
    logic [15:0] er;
    logic hit;
    #1;
    er = (addr == 2'd0) ? exp_status() : (addr == 2'd1) ? m_mask : 16'h0;
    chk({tag, " rdata"}, rdata, er);
    chk({tag, " irq"}, {15'h0, irq}, {15'h0, |(exp_status() & m_mask)});
    @(posedge clk);
    if (!rst_ni) begin
      m_latch = 0; m_mask = '0;
    end else begin
      hit = narrow ? |kbd[5:0] : |kbd;
      if (hit) m_latch = 1;
      else if (we && addr == 2'd2) m_latch = 0;
      if (we && addr == 2'd1) m_mask = wdata & 16'h3007;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
    addr = a; we = 1; wdata = d;
    cyc(tag);
    we = 0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // reset state
    addr = 0; cyc("R3 reset status");
    addr = 1; cyc("R3 reset mask");
    rst_ni = 1;
    @(negedge clk);
    addr = 0;
    srx = 1; cyc("R1 ssi rx bit1");
    srx = 0; stx = 1; cyc("R1 ssi tx bit2");
    stx = 0; utx = 1; cyc("R1 uart tx bit12");
    utx = 0; urx = 1; cyc("R1 uart rx bit13");
    srx = 1; stx = 1; utx = 1; cyc("R9 all live mask zero");
    wr(2'd1, 16'hFFFF, "R2 write all mask");
    addr = 1; cyc("R2 mask reserved zero");
    addr = 0; cyc("R8 irq with full mask");
    srx = 0; stx = 0; utx = 0; urx = 0; cyc("R8 irq drop");
    // narrow mode: lines 7:6 ignored
    narrow = 1; kbd = 8'hC0; cyc("R4 narrow high lines");
    cyc("R4 narrow high lines held");
    kbd = 8'h08; cyc("R7 one-cycle pulse");
    kbd = 8'h00; cyc("R7 latch set");
    cyc("R5 latch held");
    wr(2'd2, 16'h0000, "R5 eoi write");
    cyc("R5 latch cleared");
    // wide mode: line 7 counts
    narrow = 0; kbd = 8'h80; cyc("R4 wide line7");
    kbd = 8'h00; cyc("R4 wide latch set");
    // set and ack together
    kbd = 8'h02; wr(2'd2, 16'h1234, "R6 set with eoi");
    kbd = 8'h00; cyc("R6 latch kept");
    wr(2'd2, 16'hFFFF, "R5 eoi alone");
    cyc("R5 cleared again");
    // writes to status and unused offset
    wr(2'd1, 16'h0001, "R3 mask kbd only");
    kbd = 8'h20; cyc("R8 kbd pulse masked in");
    kbd = 8'h00; cyc("R8 irq from latch");
    srx = 1; cyc("R8 srx masked out");
    wr(2'd0, 16'hFFFF, "R10 write status offset");
    wr(2'd3, 16'h0000, "R10 write offset3");
    addr = 1; cyc("R10 mask unchanged");
    addr = 3; cyc("R10 offset3 reads zero");
    addr = 0; cyc("R10 latch unchanged");
    wr(2'd1, 16'h0002, "R3 mask srx only");
    srx = 0; cyc("R8 srx low");
    srx = 1; cyc("R8 srx high");
    finish_run();
  end
endmodule